// File: doc/BRIEF.md
# Multimaster System Bus Arbiter

Each master that shares a system bus carries one copy of this arbiter. The copies resolve ownership through a serial priority chain and three wired-OR lines. The first is the bus request. The second is a common request line, which any master that wants the bus but does not hold it raises. The third is a busy line, which the current owner holds. On its local side the arbiter accepts a request from its processor, together with a flag saying whether that cycle needs the system bus. It returns a grant and a one-clock done pulse at the end of every bus cycle it runs. A bus cycle lasts a fixed number of clocks.

A master that owns the bus keeps it from cycle to cycle and does not contend again. It gives the bus up only when the common request line and a strap-selected policy call for it. With the strap low, only a higher-priority master can take the bus away, unless the owner's own next cycle does not need the bus while common request is raised. With the strap high, any requester takes the bus away once common request is raised. A surrender always waits for the running bus cycle to finish. The chain position with the highest priority has its priority input tied high. A waiting or owning master drives its priority output low to block the masters below it. An idle master passes its priority input straight through to its priority output.

Top module: `mbus_arbiter`

## Requirements
- R1: During and after a synchronous reset, grant_o, busy_o, bus_req_o, common_req_o and done_o are low, and prio_out_o equals prio_in_i.
- R2: A local request with loc_sys_i high, made while the master does not own the bus, raises bus_req_o and common_req_o on the next clock. prio_out_o is low from then on, for as long as the master waits or owns the bus.
- R3: A waiting master takes the bus on the clock where prio_in_i is high and busy_i is low. grant_o and busy_o then go high and common_req_o goes low. bus_req_o stays high while the master owns the bus.
- R4: An owner keeps the bus through any number of cycles, and through idle time, as long as common_req_i stays low and prio_in_i stays high.
- R5: While the owner's processor holds a system request, a bus cycle starts on the clock after the grant. done_o goes high for exactly one clock, CYC_LEN+1 clocks after grant_o rises, and again every CYC_LEN+1 clocks after that.
- R6: The owner never gives up the bus while a bus cycle is running. A surrender takes effect on the clock after the cycle's done pulse at the earliest.
- R7: With surrender_any_i low, an owner whose next cycle needs the bus ignores a common request from lower masters. It gives up the bus when prio_in_i goes low.
- R8: With surrender_any_i low, an owner gives up the bus when common_req_i is high and its processor has no pending system request.
- R9: With surrender_any_i high, an owner gives up the bus whenever common_req_i is high, even when its own next cycle needs the bus.
- R10: An idle master passes prio_in_i to prio_out_o. A waiting or owning master drives prio_out_o low.
- R11: A local request with loc_sys_i low never raises bus_req_o, common_req_o or grant_o.
- R12: In a chain of three arbiters that share the wired lines, at most one master drives busy at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req_i | input | 1 | Local processor requests a cycle |
| loc_sys_i | input | 1 | The requested cycle needs the system bus |
| grant_o | output | 1 | This master owns the bus |
| done_o | output | 1 | One-clock pulse at the end of each bus cycle |
| surrender_any_i | input | 1 | Strap: 1 = yield to any requester, 0 = yield to higher priority only |
| prio_in_i | input | 1 | Priority from the next higher chain position |
| prio_out_o | output | 1 | Priority to the next lower chain position |
| busy_i | input | 1 | Wired-OR busy line, as seen on the bus |
| busy_o | output | 1 | This master drives busy |
| bus_req_o | output | 1 | This master requests or holds the bus |
| common_req_i | input | 1 | Wired-OR common request line, as seen on the bus |
| common_req_o | output | 1 | This master waits for the bus |

## Verification
The hardest case to reach is a higher-priority request that arrives while the owner is in the middle of a bus cycle. The owner must finish the running cycle, pulse done, and only then drop busy, and no master may take busy in between. The bench lets the middle chain position own the bus and keeps its processor requesting so that cycles run back to back. It then raises the top position's request mid-cycle. It confirms that the done pulse comes before the grant falls, and that the top position takes over within a clock of the release. A long randomized run over the three-master chain then checks every surrender against the strap policy in force on the clock before it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int CYC_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  localparam int CNT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      cnt      <= '0;
    end else begin
      done_o <= 1'b0;
      if (active_o) begin
        if (cnt == LAST) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start_i) begin
        active_o <= 1'b1;
        cnt      <= '0;
      end
    end
  end

  // R5: the done pulse lasts a single clock
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5: an accepted start opens a cycle
  assert_start_opens_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_o) |=> active_o);
endmodule

// File: rtl/surrender_policy.sv
module surrender_policy (
  input  logic prio_in_i,
  input  logic common_req_i,
  input  logic next_need_i,
  input  logic surrender_any_i,
  output logic release_o
);
  logic higher_waiting;
  logic idle_yield;
  logic any_yield;

  always_comb begin
    higher_waiting = !prio_in_i;
    idle_yield     = common_req_i && !next_need_i;
    any_yield      = surrender_any_i && common_req_i;
    release_o      = higher_waiting || idle_yield || any_yield;
  end
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter #(
  parameter int CYC_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic loc_req_i,
  input  logic loc_sys_i,
  output logic grant_o,
  output logic done_o,
  input  logic surrender_any_i,
  input  logic prio_in_i,
  output logic prio_out_o,
  input  logic busy_i,
  output logic busy_o,
  output logic bus_req_o,
  input  logic common_req_i,
  output logic common_req_o
);
  import arb_pkg::*;

  arb_state_e st;
  logic want;
  logic rel;
  logic active;
  logic start;

  assign want = loc_req_i && loc_sys_i;

  surrender_policy u_policy (
    .prio_in_i      (prio_in_i),
    .common_req_i   (common_req_i),
    .next_need_i    (want),
    .surrender_any_i(surrender_any_i),
    .release_o      (rel)
  );

  assign start = (st == ST_OWN) && !active && !rel && want;

  bus_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .active_o(active),
    .done_o  (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (want) st <= ST_WAIT;
        ST_WAIT: begin
          if (!want)                     st <= ST_IDLE;
          else if (prio_in_i && !busy_i) st <= ST_OWN;
        end
        ST_OWN:  if (!active && rel) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign grant_o      = (st == ST_OWN);
  assign busy_o       = (st == ST_OWN);
  assign bus_req_o    = (st != ST_IDLE);
  assign common_req_o = (st == ST_WAIT);
  assign prio_out_o   = prio_in_i && (st == ST_IDLE);

  // R6: a running bus cycle is never cut short
  assert_hold_midcycle_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && active) |=> (st == ST_OWN));
  // R3: ownership begins only with priority present and the bus free
  assert_acquire_rules_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(prio_in_i) && !$past(busy_i)));
  // R4: no contention means the owner stays
  assert_keep_uncontested_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && prio_in_i && !common_req_i) |=> (st == ST_OWN));
  // R7: lower requesters are ignored under the priority-only strap
  assert_lower_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OWN && !surrender_any_i && prio_in_i && want) |=> (st == ST_OWN));
endmodule

// File: tb/mbus_arbiter_test.sv
module mbus_arbiter_test;
  localparam int CYC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic any_s = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] sys = '0;
  logic [2:0] grant, done, busy, breq, cbrq, pout;
  logic [2:0] pin;
  logic busy_bus, cbrq_bus;

  int checks = 0;
  int errors = 0;
  int overlap = 0;

  always #5 clk = ~clk;

  assign pin = {pout[1], pout[0], 1'b1};
  assign busy_bus = |busy;
  assign cbrq_bus = |cbrq;

  mbus_arbiter #(.CYC_LEN(CYC)) uut (
    .clk(clk), .rst(rst), .loc_req_i(req[0]), .loc_sys_i(sys[0]),
    .grant_o(grant[0]), .done_o(done[0]), .surrender_any_i(any_s),
    .prio_in_i(pin[0]), .prio_out_o(pout[0]), .busy_i(busy_bus),
    .busy_o(busy[0]), .bus_req_o(breq[0]), .common_req_i(cbrq_bus),
    .common_req_o(cbrq[0]));
  mbus_arbiter #(.CYC_LEN(CYC)) u_mid (
    .clk(clk), .rst(rst), .loc_req_i(req[1]), .loc_sys_i(sys[1]),
    .grant_o(grant[1]), .done_o(done[1]), .surrender_any_i(any_s),
    .prio_in_i(pin[1]), .prio_out_o(pout[1]), .busy_i(busy_bus),
    .busy_o(busy[1]), .bus_req_o(breq[1]), .common_req_i(cbrq_bus),
    .common_req_o(cbrq[1]));
  mbus_arbiter #(.CYC_LEN(CYC)) u_low (
    .clk(clk), .rst(rst), .loc_req_i(req[2]), .loc_sys_i(sys[2]),
    .grant_o(grant[2]), .done_o(done[2]), .surrender_any_i(any_s),
    .prio_in_i(pin[2]), .prio_out_o(pout[2]), .busy_i(busy_bus),
    .busy_o(busy[2]), .bus_req_o(breq[2]), .common_req_i(cbrq_bus),
    .common_req_o(cbrq[2]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Surrender policy monitor (R7, R8, R9) and exclusive busy (R12)
  logic [2:0] pg, pp, pn;
  logic pa, pc, pr;
  always @(posedge clk) begin
    pg = grant; pp = pin; pn = req & sys; pa = any_s; pc = cbrq_bus; pr = rst;
  end
  always @(negedge clk) begin
    if (!rst && $countones(busy) > 1) overlap++;
    for (int i = 0; i < 3; i++) begin
      if (!pr && !rst && pg[i] && !grant[i]) begin
        bit ok;
        ok = pa ? (pc || !pp[i]) : (!pp[i] || (pc && !pn[i]));
        check(ok, pa ? "R9 surrender with any-strap" : "R7/R8 surrender with priority strap",
              int'(ok), 1);
      end
    end
  end

  task automatic do_reset();
    req = '0; sys = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_grant(input int idx, input int lim, output int n);
    n = 0;
    while (!grant[idx] && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    do_reset();
    check(grant == 3'b000 && busy == 3'b000, "R1 grant/busy after reset", int'({grant, busy}), 0);
    check(breq == 3'b000 && cbrq == 3'b000 && done == 3'b000, "R1 requests after reset",
          int'({breq, cbrq, done}), 0);
    check(pout == 3'b111, "R1/R10 priority passes through idle chain", int'(pout), 7);
  endtask

  task automatic t_local_only();
    do_reset();
    req[0] = 1'b1; sys[0] = 1'b0;
    repeat (6) @(negedge clk);
    check(breq[0] == 1'b0 && cbrq[0] == 1'b0 && grant[0] == 1'b0,
          "R11 local-only request ignored", int'({breq[0], cbrq[0], grant[0]}), 0);
    check(pout[0] == 1'b1, "R11/R10 priority still passed", int'(pout[0]), 1);
    req[0] = 1'b0;
  endtask

  task automatic t_acquire_keep();
    int n;
    bit lost;
    do_reset();
    req[0] = 1'b1; sys[0] = 1'b1;
    @(negedge clk);
    check(breq[0] && cbrq[0], "R2 request lines raised", int'({breq[0], cbrq[0]}), 3);
    check(pout[0] == 1'b0, "R10 priority blocked while waiting", int'(pout[0]), 0);
    @(negedge clk);
    check(grant[0] && busy[0] && !cbrq[0] && breq[0], "R3 acquired bus",
          int'({grant[0], busy[0], cbrq[0], breq[0]}), 13);
    n = 0;
    while (!done[0] && n < 20) begin @(negedge clk); n++; end
    check(n == CYC + 1, "R5 first done delay", n, CYC + 1);
    @(negedge clk);
    check(done[0] == 1'b0, "R5 done single clock", int'(done[0]), 0);
    n = 1;
    while (!done[0] && n < 20) begin @(negedge clk); n++; end
    check(n == CYC + 1, "R5 done period", n, CYC + 1);
    lost = 1'b0;
    repeat (3 * (CYC + 1)) begin @(negedge clk); if (!grant[0]) lost = 1'b1; end
    check(!lost, "R4 kept across cycles", int'(lost), 0);
    req[0] = 1'b0;
    repeat (10) begin @(negedge clk); if (!grant[0]) lost = 1'b1; end
    check(!lost && !cbrq[0], "R4 kept while idle", int'(lost), 0);
  endtask

  task automatic t_lower_blocked();
    int n;
    bit bad;
    do_reset();
    any_s = 1'b0;
    req[0] = 1'b1; sys[0] = 1'b1;
    wait_grant(0, 10, n);
    req[1] = 1'b1; sys[1] = 1'b1;
    bad = 1'b0;
    repeat (20) begin @(negedge clk); if (!grant[0] || grant[1]) bad = 1'b1; end
    check(!bad, "R7 lower request ignored by busy owner", int'(bad), 0);
    check(cbrq[1] == 1'b1, "R2 lower master keeps common request", int'(cbrq[1]), 1);
    req[0] = 1'b0;
    wait_grant(1, 15, n);
    check(grant[1] && !grant[0], "R8 owner yields when idle and common request",
          int'(grant[1:0]), 2);
    req[1] = 1'b0;
  endtask

  task automatic t_higher_preempt();
    int n;
    bit seen_done;
    do_reset();
    any_s = 1'b0;
    req[1] = 1'b1; sys[1] = 1'b1;
    wait_grant(1, 10, n);
    repeat (2) @(negedge clk);
    req[0] = 1'b1; sys[0] = 1'b1;
    seen_done = 1'b0; n = 0;
    while (grant[1] && n < 20) begin
      @(negedge clk); n++;
      if (done[1] && grant[1]) seen_done = 1'b1;
    end
    check(seen_done, "R6 cycle finished before release", int'(seen_done), 1);
    check(n <= CYC + 3, "R7 higher master preempts promptly", n, CYC + 3);
    @(negedge clk);
    check(grant[0] == 1'b1, "R3 higher master takes bus after release", int'(grant[0]), 1);
    req = '0;
  endtask

  task automatic t_any_strap();
    int n;
    do_reset();
    any_s = 1'b1;
    req[0] = 1'b1; sys[0] = 1'b1;
    wait_grant(0, 10, n);
    req[2] = 1'b1; sys[2] = 1'b1;
    wait_grant(2, 4 * CYC, n);
    check(grant[2] == 1'b1, "R9 lowest master served under any-strap", int'(grant[2]), 1);
    check(grant[0] == 1'b0, "R9 busy owner yielded", int'(grant[0]), 0);
    req = '0; any_s = 1'b0;
  endtask

  task automatic t_random();
    do_reset();
    overlap = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c % 500 == 0) any_s = ~any_s;
      for (int i = 0; i < 3; i++) begin
        req[i] = ($urandom % 4) != 0;
        sys[i] = ($urandom % 3) != 0;
      end
    end
    check(overlap == 0, "R12 never two busy masters", overlap, 0);
    req = '0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_local_only();
        t_acquire_keep();
        t_lower_blocked();
        t_higher_preempt();
        t_any_strap();
        t_random();
      end
      begin
        repeat (100000) @(negedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule